// File: doc/BRIEF.md
# Watchdog Timer with Pulse and Toggle Output

This block is an up-counting watchdog timer. Its counter is 24 bits wide by default. Software arms it by writing a starting value, a compare value and a control word. The counter then advances once per timer tick. The tick is either every second system clock or a pulse on an external prescaler input. The count can end in two ways. When the counter passes all-ones it wraps to zero and raises the overflow flag. When the counter reaches the compare value it raises the compare flag, and it can optionally restart from the start value.

A single output pin reports the overflow. In pulse mode the pin leaves its idle level for one full timer period. In toggle mode the pin starts at the level of the invert bit and flips on every overflow. The pin is intended to be wired back to the chip's own reset input. For that reason, the pin level and its drive enable are held for three extra system clocks after reset is asserted, so the reset it causes has a valid length. While the timer is disabled, the pin is not driven.

Control word, written with `wr_ctrl` on `wdata`:
- bit 0: enable
- bit 1: reload on compare
- bit 2: invert
- bit 3: compare interrupt enable
- bit 4: overflow interrupt enable
- bit 5: tick source (1 = `tick_i`, 0 = system clock divided by two)
- bits 9:6: mode

Status clear, written with `wr_stat`:
- `wdata` bit 0 clears the compare flag.
- `wdata` bit 1 clears the overflow flag.

Top module: `wdt_pulse_toggle`

## Requirements
- R1: A control write that takes the enable bit (bit 0) from 0 to 1 loads the counter with the start value at that edge. After that, the counter increments by one on every timer tick while enabled, and `count_o` shows it.
- R2: The pin is driven (`pin_oe_o` = 1) from one clock after the enabling write. It stops being driven one clock after a disabling write. While disabled, the counter holds and ignores ticks.
- R3: With bit 5 = 1, one tick is counted on each clock in which `tick_i` is high. With bit 5 = 0, one tick is counted on every second system clock, the first on the second clock after the enabling write.
- R4: A tick at all-ones wraps the counter to 0 and sets the overflow flag. `ovf_irq_o` is the overflow flag ANDed with bit 4.
- R5: Any edge at which the counter takes a value equal to the compare register sets the compare flag. `cmp_irq_o` is the compare flag ANDed with bit 3.
- R6: With bit 1 = 1, a tick while the counter equals the compare register reloads the start value. With bit 1 = 0, such a tick increments the counter.
- R7: A start-value write (`wr_load`) while enabled replaces the counter at the same edge. While disabled, it only stores the value.
- R8: In pulse mode (mode bits 9:6 set to any code except 4'b1010, for example 4'b1001), the enabled pin idles at the inverse of bit 2. The pin shows the bit 2 level from one clock after an overflow tick until one clock after the next tick.
- R9: In toggle mode (mode bits 9:6 = 4'b1010), the pin equals bit 2 one clock after enabling and inverts one clock after each overflow.
- R10: A `wr_stat` write clears each flag whose bit is 1. If a flag is set and cleared at the same edge, the set wins.
- R11: After `rst_n` falls, `pin_o` and `pin_oe_o` keep their values for three rising clock edges. At the fourth edge they go to 0.
- R12: After reset, the counter, both flags, both interrupts, `pin_o` and `pin_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick_i | input | 1 | Prescaler tick, one system clock wide |
| wr_ctrl | input | 1 | Control word write strobe |
| wr_load | input | 1 | Start value write strobe |
| wr_cmp | input | 1 | Compare value write strobe |
| wr_stat | input | 1 | Flag clear strobe (write 1 to clear) |
| wdata | input | CNT_W | Write data for all strobes |
| count_o | output | CNT_W | Current counter value |
| cmp_flag_o | output | 1 | Compare flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_irq_o | output | 1 | Compare interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |
| pin_o | output | 1 | Timer output pin level |
| pin_oe_o | output | 1 | Timer output pin drive enable |

## Verification
A flag can be set by the counter and cleared by software in the same clock. The bench provokes this by asserting a tick that lands the counter on the compare value in the same clock as a status write that clears the compare flag. The flag must read 1 afterwards, because setting wins. A following clear on its own must then take the flag to 0. A start-value write can also meet a tick in the same cycle; there the write must win, which the bench checks through the counter value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Control word bit positions (decoded by wdt_pulse_toggle)
   localparam int CTL_W       = 10;
   localparam int STAT_CMP    = 0;
   localparam int STAT_OVF    = 1;
   localparam int MODE_W      = 4;
   localparam logic [MODE_W-1:0] MODE_PULSE  = 4'b1001;
   localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b1010;

   typedef struct packed {
      logic [MODE_W-1:0] mode;  // 9:6
      logic              src;   // 5  1 = external tick
      logic              oie;   // 4
      logic              cie;   // 3
      logic              inv;   // 2
      logic              rld;   // 1
      logic              en;    // 0
   } ctl_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic src_ext,
   input  logic tick_i,
   output logic tclk_en
);
   logic div_q;

   // Halved system clock: held low while stopped so the first
   // tick lands on the second edge after enabling.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= 1'b0;
      else if (!run) div_q <= 1'b0;
      else           div_q <= ~div_q;
   end

   assign tclk_en = run & (src_ext ? tick_i : div_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             start,
   input  logic             tclk_en,
   input  logic             rld,
   input  logic             wr_load,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             cmp_hit_o,
   output logic             ovf_evt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q, load_q, cmp_q, cnt_nxt;
   logic             cnt_we, wrap;

   always_comb begin
      cnt_nxt = cnt_q;
      cnt_we  = 1'b0;
      wrap    = 1'b0;
      if (start) begin
         cnt_nxt = load_q;
         cnt_we  = 1'b1;
      end else if (run && wr_load) begin
         cnt_nxt = wdata;
         cnt_we  = 1'b1;
      end else if (tclk_en) begin
         cnt_we = 1'b1;
         if (rld && (cnt_q == cmp_q)) begin
            cnt_nxt = load_q;
         end else begin
            cnt_nxt = cnt_q + 1'b1;
            wrap    = (cnt_q == CNT_MAX);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (cnt_we)  cnt_q  <= cnt_nxt;
         if (wr_load) load_q <= wdata;
         if (wr_cmp)  cmp_q  <= wdata;
      end
   end

   assign cnt_o     = cnt_q;
   assign cmp_o     = cmp_q;
   assign cmp_hit_o = cnt_we && (cnt_nxt == cmp_q);
   assign ovf_evt_o = wrap;
endmodule

// File: rtl/wdt_wave.sv
module wdt_wave (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic start,
   input  logic tclk_en,
   input  logic ovf_evt,
   input  logic inv,
   input  logic toggle_sel,
   output logic core_pin,
   output logic tog_o
);
   logic pulse_q, flip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         flip_q  <= 1'b0;
      end else begin
         if (start || !run) pulse_q <= 1'b0;
         else if (tclk_en)  pulse_q <= ovf_evt;
         if (start)         flip_q  <= 1'b0;
         else if (ovf_evt)  flip_q  <= ~flip_q;
      end
   end

   assign core_pin = run & (toggle_sel ? (inv ^ flip_q) : (~inv ^ pulse_q));
   assign tog_o    = flip_q;
endmodule

// File: rtl/wdt_pin_hold.sv
module wdt_pin_hold #(
   parameter int HOLD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic core_pin,
   input  logic core_oe,
   output logic pin_o,
   output logic pin_oe_o
);
   logic pin_q, oe_q;

   if (HOLD_CYC > 0) begin : g_hold
      localparam int HW = $clog2(HOLD_CYC + 1);
      localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);
      logic [HW-1:0] hold_cnt;
      // Deliberately outside the reset it must outlast.
      always_ff @(posedge clk) begin
         if (rst_n) begin
            hold_cnt <= '0;
            pin_q    <= core_pin;
            oe_q     <= core_oe;
         end else if (hold_cnt != HOLD_V) begin
            hold_cnt <= hold_cnt + 1'b1;
         end else begin
            pin_q <= core_pin;
            oe_q  <= core_oe;
         end
      end
   end else begin : g_nohold
      always_ff @(posedge clk) begin
         pin_q <= core_pin;
         oe_q  <= core_oe;
      end
   end

   assign pin_o    = pin_q;
   assign pin_oe_o = oe_q;
endmodule

// File: rtl/wdt_pulse_toggle.sv
module wdt_pulse_toggle
   import wdt_pkg::*;
#(
   parameter int CNT_W    = 24,
   parameter int HOLD_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_ctrl,
   input  logic             wr_load,
   input  logic             wr_cmp,
   input  logic             wr_stat,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count_o,
   output logic             cmp_flag_o,
   output logic             ovf_flag_o,
   output logic             cmp_irq_o,
   output logic             ovf_irq_o,
   output logic             pin_o,
   output logic             pin_oe_o
);
   if (CNT_W < CTL_W) begin : g_bad_width
      $error("CNT_W must cover the control word");
   end
   if (HOLD_CYC > 15) begin : g_bad_hold
      $error("HOLD_CYC out of range");
   end

   ctl_t             ctl_q, ctl_wr;
   logic             start, run, toggle_sel, tclk_en;
   logic             cmp_hit, ovf_evt, core_pin, tog_q;
   logic             cmp_flag_q, ovf_flag_q;
   logic [CNT_W-1:0] cnt_q, cmp_q;

   assign ctl_wr     = ctl_t'(wdata[CTL_W-1:0]);
   assign run        = ctl_q.en;
   assign start      = wr_ctrl & ctl_wr.en & ~ctl_q.en;
   assign toggle_sel = (ctl_q.mode == MODE_TOGGLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         cmp_flag_q <= 1'b0;
         ovf_flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctl_q <= ctl_wr;
         if (cmp_hit)                          cmp_flag_q <= 1'b1;
         else if (wr_stat && wdata[STAT_CMP])  cmp_flag_q <= 1'b0;
         if (ovf_evt)                          ovf_flag_q <= 1'b1;
         else if (wr_stat && wdata[STAT_OVF])  ovf_flag_q <= 1'b0;
      end
   end

   wdt_tick_gen u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .src_ext (ctl_q.src),
      .tick_i  (tick_i),
      .tclk_en (tclk_en)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .start     (start),
      .tclk_en   (tclk_en),
      .rld       (ctl_q.rld),
      .wr_load   (wr_load),
      .wr_cmp    (wr_cmp),
      .wdata     (wdata),
      .cnt_o     (cnt_q),
      .cmp_o     (cmp_q),
      .cmp_hit_o (cmp_hit),
      .ovf_evt_o (ovf_evt)
   );

   wdt_wave u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .start      (start),
      .tclk_en    (tclk_en),
      .ovf_evt    (ovf_evt),
      .inv        (ctl_q.inv),
      .toggle_sel (toggle_sel),
      .core_pin   (core_pin),
      .tog_o      (tog_q)
   );

   wdt_pin_hold #(.HOLD_CYC(HOLD_CYC)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .core_pin (core_pin),
      .core_oe  (run),
      .pin_o    (pin_o),
      .pin_oe_o (pin_oe_o)
   );

   assign count_o    = cnt_q;
   assign cmp_flag_o = cmp_flag_q;
   assign ovf_flag_o = ovf_flag_q;
   assign cmp_irq_o  = cmp_flag_q & ctl_q.cie;
   assign ovf_irq_o  = ovf_flag_q & ctl_q.oie;
endmodule

// File: rtl/wdt_pulse_toggle_chk.sv
module wdt_pulse_toggle_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tclk_en,
   input logic             rld,
   input logic             wr_load,
   input logic             wr_stat,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_q,
   input logic             ovf_evt,
   input logic             toggle_sel,
   input logic             tog_q,
   input logic             cmp_flag,
   input logic             ovf_flag,
   input logic             pin_oe
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tclk_en && !wr_load && !(rld && cnt == cmp_q) && cnt != MAXV)
      |=> (cnt - $past(cnt)) == CNT_W'(1));

   // R4
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tclk_en && !wr_load && !(rld && cnt == cmp_q) && cnt == MAXV)
      |=> (cnt == '0) && ovf_flag);

   // R7
   load_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wr_load) |=> cnt == $past(wdata));

   // R2
   float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pin_oe);

   // R9
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && toggle_sel && ovf_evt) |=> tog_q != $past(tog_q));

   // R10
   cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flag && !wr_stat) |=> cmp_flag);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !wr_stat) |=> ovf_flag);
endmodule

bind wdt_pulse_toggle wdt_pulse_toggle_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .tclk_en    (tclk_en),
   .rld        (ctl_q.rld),
   .wr_load    (wr_load),
   .wr_stat    (wr_stat),
   .wdata      (wdata),
   .cnt        (cnt_q),
   .cmp_q      (cmp_q),
   .ovf_evt    (ovf_evt),
   .toggle_sel (toggle_sel),
   .tog_q      (tog_q),
   .cmp_flag   (cmp_flag_q),
   .ovf_flag   (ovf_flag_q),
   .pin_oe     (pin_oe_o)
);

// File: tb/wdt_pulse_toggle_bench.sv
module wdt_pulse_toggle_bench;
   localparam int W = 24;
   localparam logic [W-1:0] MAXV = '1;
   localparam logic [3:0] PULSE = 4'b1001;
   localparam logic [3:0] TOGG  = 4'b1010;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_i = 1'b0;
   logic         wr_ctrl = 1'b0, wr_load = 1'b0, wr_cmp = 1'b0, wr_stat = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] count_o;
   logic         cmp_flag_o, ovf_flag_o, cmp_irq_o, ovf_irq_o, pin_o, pin_oe_o;
   int           checks = 0;
   int           errors = 0;

   always #2 clk = ~clk;

   wdt_pulse_toggle u_wdt_pulse_toggle (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .wr_ctrl(wr_ctrl), .wr_load(wr_load), .wr_cmp(wr_cmp), .wr_stat(wr_stat),
      .wdata(wdata), .count_o(count_o),
      .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o),
      .cmp_irq_o(cmp_irq_o), .ovf_irq_o(ovf_irq_o),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o)
   );

   function automatic logic [W-1:0] ctl(input bit en, input bit rld, input bit inv,
                                        input bit cie, input bit oie, input bit src,
                                        input logic [3:0] mode);
      return {14'd0, mode, src, oie, cie, inv, rld, en};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // sel: 0 ctrl, 1 load, 2 cmp, 3 stat
   task automatic wr(input int sel, input logic [W-1:0] d);
      wdata = d;
      wr_ctrl = (sel == 0); wr_load = (sel == 1); wr_cmp = (sel == 2); wr_stat = (sel == 3);
      @(negedge clk);
      wr_ctrl = 1'b0; wr_load = 1'b0; wr_cmp = 1'b0; wr_stat = 1'b0;
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      check("R12 count", count_o, 0);
      check("R12 flags", {cmp_flag_o, ovf_flag_o}, 0);
      check("R12 irqs", {cmp_irq_o, ovf_irq_o}, 0);
      check("R12 pin/oe", {pin_o, pin_oe_o}, 0);
   endtask

   task automatic t_enable_count();
      wr(1, 24'd10);
      wr(0, ctl(1, 0, 0, 0, 0, 1, PULSE));
      check("R1 start load", count_o, 10);
      check("R2 oe lags enable", pin_oe_o, 0);
      idle(1);
      check("R2 oe driven", pin_oe_o, 1);
      tick_n(3);
      check("R1 per-tick count", count_o, 13);
      idle(2);
      check("R3 no tick no count", count_o, 13);
      wr(0, ctl(0, 0, 0, 0, 0, 1, PULSE));
      idle(1);
      check("R2 oe released", pin_oe_o, 0);
      tick_n(2);
      check("R2 disabled holds", count_o, 13);
   endtask

   task automatic t_div2();
      wr(1, 24'd100);
      wr(0, ctl(1, 0, 0, 0, 0, 0, PULSE));
      idle(1);
      check("R3 div2 first clock", count_o, 100);
      idle(1);
      check("R3 div2 second clock", count_o, 101);
      idle(8);
      check("R3 div2 ten clocks", count_o, 105);
      wr(0, 24'd0);
   endtask

   task automatic t_compare();
      wr(3, 24'd3);
      wr(1, 24'd5);
      wr(2, 24'd7);
      wr(0, ctl(1, 1, 0, 1, 0, 1, PULSE));
      tick_n(1);
      check("R5 no match", cmp_flag_o, 0);
      tick_n(1);
      check("R5 match sets flag", {cmp_flag_o, cmp_irq_o}, 2'b11);
      tick_n(1);
      check("R6 reload on compare", count_o, 5);
      wr(3, 24'd1);
      check("R10 clear cmp", {cmp_flag_o, cmp_irq_o}, 2'b00);
      wr(0, ctl(1, 0, 0, 1, 0, 1, PULSE));
      check("R1 re-enable keeps count", count_o, 5);
      tick_n(3);
      check("R6 no reload continues", count_o, 8);
      check("R5 flag after second match", cmp_flag_o, 1);
      wr(0, ctl(1, 0, 0, 0, 0, 1, PULSE));
      check("R5 irq gated", {cmp_flag_o, cmp_irq_o}, 2'b10);
      wr(0, 24'd0);
      wr(3, 24'd3);
   endtask

   task automatic t_load_write();
      wr(1, 24'd20);
      wr(0, ctl(1, 0, 0, 0, 0, 1, PULSE));
      tick_n(2);
      check("R1 count", count_o, 22);
      wr(1, 24'd500);
      check("R7 load while enabled", count_o, 500);
      // write meets a tick: write wins
      wdata = 24'd600; wr_load = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      wr_load = 1'b0; tick_i = 1'b0;
      check("R7 load beats tick", count_o, 600);
      wr(0, 24'd0);
      wr(1, 24'd900);
      check("R7 load while disabled", count_o, 600);
   endtask

   task automatic t_pulse();
      wr(3, 24'd3);
      wr(2, 24'h100);
      wr(1, MAXV - 1);
      wr(0, ctl(1, 0, 1, 0, 1, 1, PULSE));
      idle(1);
      check("R8 idle inv=1", {pin_o, pin_oe_o}, 2'b01);
      tick_n(1);
      check("R1 to max", count_o, MAXV);
      tick_n(1);
      check("R4 wrap", count_o, 0);
      check("R4 ovf flag/irq", {ovf_flag_o, ovf_irq_o}, 2'b11);
      check("R8 pin lags", pin_o, 0);
      idle(1);
      check("R8 pulse active", pin_o, 1);
      idle(3);
      check("R8 pulse held to next tick", pin_o, 1);
      tick_n(1);
      idle(1);
      check("R8 pulse ends", pin_o, 0);
      wr(0, 24'd0);
      wr(3, 24'd3);
      wr(1, MAXV);
      wr(0, ctl(1, 0, 0, 0, 0, 1, PULSE));
      idle(1);
      check("R8 idle inv=0", pin_o, 1);
      tick_n(1);
      check("R4 irq gated", {ovf_flag_o, ovf_irq_o}, 2'b10);
      idle(1);
      check("R8 active low", pin_o, 0);
      tick_n(1);
      idle(1);
      check("R8 back high", pin_o, 1);
      wr(0, 24'd0);
      wr(3, 24'd3);
   endtask

   task automatic t_toggle();
      wr(1, MAXV);
      wr(0, ctl(1, 0, 1, 0, 0, 1, TOGG));
      idle(1);
      check("R9 start at inv=1", pin_o, 1);
      tick_n(1);
      idle(1);
      check("R9 first flip", pin_o, 0);
      wr(1, MAXV);
      tick_n(1);
      idle(1);
      check("R9 second flip", pin_o, 1);
      wr(0, 24'd0);
      wr(0, ctl(1, 0, 0, 0, 0, 1, TOGG));
      idle(1);
      check("R9 start at inv=0", pin_o, 0);
      tick_n(1);
      idle(1);
      check("R9 flip from 0", pin_o, 1);
      wr(0, 24'd0);
      wr(3, 24'd3);
   endtask

   task automatic t_collision();
      wr(1, 24'd0);
      wr(2, 24'd2);
      wr(0, ctl(1, 0, 0, 1, 0, 1, PULSE));
      tick_n(1);
      check("R5 before match", cmp_flag_o, 0);
      wdata = 24'd1; wr_stat = 1'b1; tick_i = 1'b1;
      @(negedge clk);
      wr_stat = 1'b0; tick_i = 1'b0;
      check("R10 set wins over clear", cmp_flag_o, 1);
      wr(3, 24'd2);
      check("R10 ovf-only clear leaves cmp", cmp_flag_o, 1);
      wr(3, 24'd1);
      check("R10 lone clear", cmp_flag_o, 0);
      wr(0, 24'd0);
   endtask

   task automatic t_reset_hold();
      wr(1, 24'd0);
      wr(0, ctl(1, 0, 1, 0, 0, 1, TOGG));
      idle(1);
      check("R11 driven before reset", {pin_o, pin_oe_o}, 2'b11);
      rst_n = 1'b0;
      idle(1);
      check("R11 hold edge 1", {pin_o, pin_oe_o}, 2'b11);
      check("R12 count cleared", count_o, 0);
      idle(1);
      check("R11 hold edge 2", {pin_o, pin_oe_o}, 2'b11);
      idle(1);
      check("R11 hold edge 3", {pin_o, pin_oe_o}, 2'b11);
      idle(1);
      check("R11 released edge 4", {pin_o, pin_oe_o}, 2'b00);
      rst_n = 1'b1;
      idle(2);
      t_reset_state();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset_state();
      t_enable_count();
      t_div2();
      t_compare();
      t_load_write();
      t_pulse();
      t_toggle();
      t_collision();
      t_reset_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule